// File: doc/BRIEF.md
# Byte-Wide Serial Port with Paired Set/Clear Status Addresses

This block is an asynchronous serial transmitter and receiver that sits on a simple byte-wide register bus. A 16-bit divisor drives an oversampling tick generator; sixteen ticks make one bit time. The frame format is chosen in the control register: 7 or 8 data bits sent least significant bit first, optional even or odd parity, and one or two stop bits. The transmit path has a single holding register in front of a shift register. The receive path keeps one received byte.

The line status and handshake status registers each appear at two addresses. The first address reads the register, and a write there clears the bits written as one. The second address is write-only and sets the bits written as one. Transmit and receive data share a single address. A read there returns the received byte, and a write there loads the holding register.

The block also provides internal loopback, automatic echo of the receive line and forced break on the transmit line. Two modem control outputs and two modem status inputs are plain register bits. A single interrupt output combines the enabled receive, transmit and error conditions.

Top module: `dualaddr_uart`

## Requirements
- R1: After reset the line status register (offset 0x00) reads 0x06, meaning holding empty (bit2) and shifter empty (bit1) are set. The divisor, control, receive command and transmit command registers read 0. txd is 1, irq is 0, and dtr_o and rts_o are 0.
- R2: The divisor high byte is at 0x10 and the low byte at 0x14, and both read back. One bit time lasts 16×(divisor+1) clocks.
- R3: Transmit frame format is set by control bits at 0x18. The frame is a start bit (0), then the data LSB first: 8 bits when bit3=1, 7 bits when bit3=0. A parity bit follows when bit2=1; it is odd when bit1=1 and even otherwise. Then come the stop bits: two when bit0=1, one otherwise. With the transmit command (0x20) bit7 set, a write to 0x24 clears holding empty. The start bit appears on txd one clock after the holding register moves into the shifter. Shifter empty is set again when the frame ends.
- R4: With receive command bit7 set, a received frame sets data ready (line status bit7). A read of 0x24 returns the byte and clears data ready.
- R5: If a frame completes while data ready is still set and is not being cleared in that cycle, overrun (bit5) is set and the buffer holds the newer byte.
- R6: A stop bit sampled low sets framing error (bit6). A parity mismatch sets parity error (bit4). If data, parity and stop all sample low, break received (bit3) is also set.
- R7: Writing to 0x00 clears every line status bit written as one. Writing to 0x04 sets every line status bit written as one.
- R8: Handshake status at 0x08 has bit7 set while dsr_i is high and bit6 set while cts_i is high. Both bits stay set until cleared by a write of ones to 0x08. A write of ones to 0x0C sets them.
- R9: dtr_o follows control bit5 and rts_o follows control bit4.
- R10: With control bit6 set (loopback), the transmit stream feeds the receiver and txd stays 1.
- R11: With control bit7 set (auto-echo) and loopback clear, txd follows rxd and no held byte is started. The held byte is sent once auto-echo is cleared.
- R12: Transmit command bit1 forces the transmitted line low. Bit2 holds back the start of a new frame.
- R13: irq is high when any of these holds: receive command bits6:5 = 01 and data ready; transmit command bits6:5 = 01 with bit4 set and holding empty; any of line status bits6:3 set while receive command bit4 or transmit command bit3 is set.
- R14: When a data write and the transfer of the holding register into the shifter fall in the same cycle, holding empty ends clear. Both bytes are then sent in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the access cycle |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| dsr_i | input | 1 | Modem status input, high = asserted |
| cts_i | input | 1 | Modem status input, high = asserted |
| dtr_o | output | 1 | Modem control output |
| rts_o | output | 1 | Modem control output |
| irq | output | 1 | Interrupt request |

## Verification
The risky coincidence is a software write to the data address in the same cycle that the holding register moves into the shifter: one event sets holding empty while the other clears it. The bench provokes this by issuing two data writes on consecutive clocks with the divisor at zero, so the first write's transfer lands exactly on the second write. It then requires holding empty to read 0 and decodes both frames from txd in the order written. The same ordering rule covers a frame completing while data ready is being cleared by software; the design keeps data ready set in that case.

// File: rtl/dualaddr_uart_pkg.sv
package dualaddr_uart_pkg;
  localparam int DIV_W   = 16;
  localparam int FRAME_W = 12;
  localparam int ACC_W   = 10;

  localparam logic [5:0] OFS_LSR  = 6'h00;
  localparam logic [5:0] OFS_LSRS = 6'h04;
  localparam logic [5:0] OFS_HSR  = 6'h08;
  localparam logic [5:0] OFS_HSRS = 6'h0C;
  localparam logic [5:0] OFS_DIVH = 6'h10;
  localparam logic [5:0] OFS_DIVL = 6'h14;
  localparam logic [5:0] OFS_CTL  = 6'h18;
  localparam logic [5:0] OFS_RCMD = 6'h1C;
  localparam logic [5:0] OFS_TCMD = 6'h20;
  localparam logic [5:0] OFS_DATA = 6'h24;

  typedef struct packed {
    logic eight;
    logic par_en;
    logic par_odd;
    logic two_stop;
  } fmt_t;
endpackage

// File: rtl/dualaddr_baud.sv
module dualaddr_baud
  import dualaddr_uart_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = (cnt_q >= div);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;

  p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != '0) |=> (!tick || div == '0));
endmodule

// File: rtl/dualaddr_tx.sv
module dualaddr_tx
  import dualaddr_uart_pkg::*;
#(
  parameter int OVS = 16
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       load,
  input  logic [7:0] data,
  input  fmt_t       fmt,
  input  logic       brk,
  output logic       busy,
  output logic       done,
  output logic       line
);
  localparam int PW = $clog2(OVS);
  localparam logic [PW-1:0] PH_LAST = PW'(OVS - 1);

  logic [FRAME_W-1:0] sh_q, sh_d, frame;
  logic [3:0]         left_q, left_d, nbits;
  logic [PW-1:0]      ph_q, ph_d;
  logic               busy_q, busy_d, par;

  always_comb begin
    par   = (^(data & {fmt.eight, 7'h7f})) ^ fmt.par_odd;
    frame = '1;
    frame[0]   = 1'b0;
    frame[7:1] = data[6:0];
    if (fmt.eight) frame[8] = data[7];
    if (fmt.par_en) begin
      if (fmt.eight) frame[9] = par;
      else           frame[8] = par;
    end
    nbits = 4'd9 + {3'b0, fmt.eight} + {3'b0, fmt.par_en} + {3'b0, fmt.two_stop};

    sh_d   = sh_q;
    left_d = left_q;
    ph_d   = ph_q;
    busy_d = busy_q;
    done   = 1'b0;
    if (load && !busy_q) begin
      sh_d   = frame;
      left_d = nbits;
      ph_d   = '0;
      busy_d = 1'b1;
    end else if (busy_q && tick) begin
      ph_d = ph_q + 1'b1;
      if (ph_q == PH_LAST) begin
        sh_d   = {1'b1, sh_q[FRAME_W-1:1]};
        left_d = left_q - 1'b1;
        if (left_q == 4'd1) begin
          busy_d = 1'b0;
          done   = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sh_q   <= '1;
      left_q <= '0;
      ph_q   <= '0;
      busy_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      left_q <= left_d;
      ph_q   <= ph_d;
      busy_q <= busy_d;
    end

  assign busy = busy_q;
  assign line = brk ? 1'b0 : (busy_q ? sh_q[0] : 1'b1);

  p_start_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy_q) && !brk) |-> !line);
endmodule

// File: rtl/dualaddr_rx.sv
module dualaddr_rx
  import dualaddr_uart_pkg::*;
#(
  parameter int OVS = 16
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       en,
  input  logic       rx_in,
  input  fmt_t       fmt,
  output logic       done,
  output logic [7:0] data,
  output logic       fe,
  output logic       pe,
  output logic       brk
);
  localparam int PW = $clog2(OVS);
  localparam logic [PW-1:0] PH_MID = PW'(OVS / 2 - 1);

  logic [2:0]       s_q;
  logic             act_q, act_d, done_d, fe_d, pe_d, brk_d;
  logic [PW-1:0]    ph_q, ph_d;
  logic [3:0]       idx_q, idx_d, nrx;
  logic [ACC_W-1:0] acc_q, acc_d, al;
  logic [7:0]       data_q, data_d;
  logic             smp, pb, stp;

  assign smp = s_q[1];

  always_comb begin
    nrx    = 4'd8 + {3'b0, fmt.eight} + {3'b0, fmt.par_en};
    act_d  = act_q;
    ph_d   = ph_q;
    idx_d  = idx_q;
    acc_d  = acc_q;
    done_d = 1'b0;
    data_d = data_q;
    fe_d   = fe;
    pe_d   = pe;
    brk_d  = brk;
    al     = '0;
    pb     = 1'b0;
    stp    = 1'b1;
    if (!en) begin
      act_d = 1'b0;
    end else if (!act_q) begin
      if (s_q[2] && !smp) begin
        act_d = 1'b1;
        ph_d  = '0;
        idx_d = '0;
      end
    end else if (tick) begin
      ph_d = ph_q + 1'b1;
      if (ph_q == PH_MID) begin
        if (idx_q == 4'd0) begin
          if (smp) act_d = 1'b0;
          else     idx_d = 4'd1;
        end else begin
          acc_d = {smp, acc_q[ACC_W-1:1]};
          idx_d = idx_q + 1'b1;
          if (idx_q == nrx) begin
            al     = acc_d >> (4'd10 - nrx);
            data_d = fmt.eight ? al[7:0] : {1'b0, al[6:0]};
            pb     = al[4'd7 + {3'b0, fmt.eight}];
            stp    = al[nrx - 4'd1];
            fe_d   = ~stp;
            pe_d   = fmt.par_en & (pb ^ (^data_d) ^ fmt.par_odd);
            brk_d  = ~stp & ~(|data_d) & ~(fmt.par_en & pb);
            done_d = 1'b1;
            act_d  = 1'b0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s_q    <= '1;
      act_q  <= 1'b0;
      ph_q   <= '0;
      idx_q  <= '0;
      acc_q  <= '0;
      done   <= 1'b0;
      data_q <= '0;
      fe     <= 1'b0;
      pe     <= 1'b0;
      brk    <= 1'b0;
    end else begin
      s_q    <= {s_q[1:0], rx_in};
      act_q  <= act_d;
      ph_q   <= ph_d;
      idx_q  <= idx_d;
      acc_q  <= acc_d;
      done   <= done_d;
      data_q <= data_d;
      fe     <= fe_d;
      pe     <= pe_d;
      brk    <= brk_d;
    end

  assign data = data_q;

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/dualaddr_uart.sv
module dualaddr_uart
  import dualaddr_uart_pkg::*;
#(
  parameter int OVS = 16
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic [5:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       rxd,
  output logic       txd,
  input  logic       dsr_i,
  input  logic       cts_i,
  output logic       dtr_o,
  output logic       rts_o,
  output logic       irq
);
  logic [7:0]       lsr_q, lsr_d, ctl_q, ctl_d, rcmd_q, rcmd_d, tcmd_q, tcmd_d, hold_q, hold_d;
  logic [1:0]       hsr_q, hsr_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic             wr_acc, rd_acc, lsr_clr, lsr_set, data_wr, data_rd;
  logic             tick, tx_load, tx_busy, tx_done, tx_line;
  logic             rx_done, rx_fe, rx_pe, rx_brk, rx_src;
  logic [7:0]       rx_data;
  fmt_t             fmt;

  assign fmt     = fmt_t'(ctl_q[3:0]);
  assign wr_acc  = bus_sel & bus_wr;
  assign rd_acc  = bus_sel & ~bus_wr;
  assign lsr_clr = wr_acc && (bus_addr == OFS_LSR);
  assign lsr_set = wr_acc && (bus_addr == OFS_LSRS);
  assign data_wr = wr_acc && (bus_addr == OFS_DATA);
  assign data_rd = rd_acc && (bus_addr == OFS_DATA);
  assign tx_load = tcmd_q[7] & ~tcmd_q[2] & ~ctl_q[7] & ~lsr_q[2] & ~tx_busy;
  assign rx_src  = ctl_q[6] ? tx_line : rxd;

  dualaddr_baud u_baud (.clk(clk), .rst_n(rst_n), .div(div_q), .tick(tick));

  dualaddr_tx #(.OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(tx_load), .data(hold_q),
    .fmt(fmt), .brk(tcmd_q[1]), .busy(tx_busy), .done(tx_done), .line(tx_line));

  dualaddr_rx #(.OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en(rcmd_q[7]), .rx_in(rx_src),
    .fmt(fmt), .done(rx_done), .data(rx_data), .fe(rx_fe), .pe(rx_pe), .brk(rx_brk));

  always_comb begin
    lsr_d = lsr_q;
    if (lsr_clr) lsr_d = lsr_d & ~bus_wdata;
    if (lsr_set) lsr_d = lsr_d | bus_wdata;
    if (data_rd) lsr_d[7] = 1'b0;
    if (rx_done) begin
      lsr_d[5] = lsr_d[5] | lsr_d[7];
      lsr_d[7] = 1'b1;
      lsr_d[6] = lsr_d[6] | rx_fe;
      lsr_d[4] = lsr_d[4] | rx_pe;
      lsr_d[3] = lsr_d[3] | rx_brk;
    end
    if (tx_load) begin
      lsr_d[2] = 1'b1;
      lsr_d[1] = 1'b0;
    end
    if (tx_done) lsr_d[1] = 1'b1;
    if (data_wr) lsr_d[2] = 1'b0;
    lsr_d[0] = 1'b0;

    hsr_d = hsr_q;
    if (wr_acc && bus_addr == OFS_HSR)  hsr_d = hsr_d & ~bus_wdata[7:6];
    if (wr_acc && bus_addr == OFS_HSRS) hsr_d = hsr_d | bus_wdata[7:6];
    hsr_d = hsr_d | {dsr_i, cts_i};

    div_d  = div_q;
    ctl_d  = ctl_q;
    rcmd_d = rcmd_q;
    tcmd_d = tcmd_q;
    hold_d = data_wr ? bus_wdata : hold_q;
    if (wr_acc) begin
      case (bus_addr)
        OFS_DIVH: div_d[15:8] = bus_wdata;
        OFS_DIVL: div_d[7:0]  = bus_wdata;
        OFS_CTL:  ctl_d       = bus_wdata;
        OFS_RCMD: rcmd_d      = bus_wdata;
        OFS_TCMD: tcmd_d      = bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lsr_q  <= 8'h06;
      hsr_q  <= '0;
      div_q  <= '0;
      ctl_q  <= '0;
      rcmd_q <= '0;
      tcmd_q <= '0;
      hold_q <= '0;
    end else begin
      lsr_q  <= lsr_d;
      hsr_q  <= hsr_d;
      div_q  <= div_d;
      ctl_q  <= ctl_d;
      rcmd_q <= rcmd_d;
      tcmd_q <= tcmd_d;
      hold_q <= hold_d;
    end

  always_comb begin
    case (bus_addr)
      OFS_LSR:  bus_rdata = lsr_q;
      OFS_HSR:  bus_rdata = {hsr_q, 6'b0};
      OFS_DIVH: bus_rdata = div_q[15:8];
      OFS_DIVL: bus_rdata = div_q[7:0];
      OFS_CTL:  bus_rdata = ctl_q;
      OFS_RCMD: bus_rdata = rcmd_q;
      OFS_TCMD: bus_rdata = tcmd_q;
      OFS_DATA: bus_rdata = rx_data;
      default:  bus_rdata = 8'h00;
    endcase
  end

  assign txd   = ctl_q[6] ? 1'b1 : (ctl_q[7] ? rxd : tx_line);
  assign dtr_o = ctl_q[5];
  assign rts_o = ctl_q[4];
  assign irq   = ((rcmd_q[6:5] == 2'b01) & lsr_q[7])
               | ((tcmd_q[6:5] == 2'b01) & tcmd_q[4] & lsr_q[2])
               | ((rcmd_q[4] | tcmd_q[3]) & (|lsr_q[6:3]));

  p_ready_on_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> lsr_q[7]);

  p_overrun_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && lsr_q[7] && !data_rd && !(lsr_clr && bus_wdata[7])) |=> lsr_q[5]);

  p_load_from_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> $past(!lsr_q[2]));

  p_echo_blocks_tx_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[7] && !tx_busy) |=> !tx_busy);

  p_write_beats_load_r14: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && tx_load) |=> !lsr_q[2]);
endmodule

// File: tb/sim_dualaddr_uart.sv
`timescale 1ns/1ps
module sim_dualaddr_uart;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       rxd = 1'b1, dsr_i = 1'b0, cts_i = 1'b0;
  logic       txd, dtr_o, rts_o, irq;
  int         n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  dualaddr_uart u0 (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rxd(rxd),
    .txd(txd), .dsr_i(dsr_i), .cts_i(cts_i), .dtr_o(dtr_o), .rts_o(rts_o), .irq(irq));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_sel = 1'b0;
  endtask

  task automatic rdchk(input logic [5:0] a, input logic [7:0] exp, input string req);
    logic [7:0] v;
    rd(a, v);
    chk(req, int'(v), int'(exp));
  endtask

  // behavioural line monitor: waits for a start bit, samples mid-bit
  task automatic mon(input int nb, input int bc, output logic [11:0] b);
    int t;
    t = 0;
    b = '1;
    do begin @(negedge clk); t++; end while (txd !== 1'b0 && t < 5000);
    repeat (bc / 2) @(negedge clk);
    b[0] = txd;
    for (int i = 1; i < nb; i++) begin
      repeat (bc) @(negedge clk);
      b[i] = txd;
    end
  endtask

  // behavioural line driver, 16 clocks per bit (divisor 0)
  task automatic send(input int nb, input logic [11:0] b);
    for (int i = 0; i < nb; i++) begin
      @(negedge clk); rxd = b[i];
      repeat (15) @(negedge clk);
    end
    @(negedge clk); rxd = 1'b1;
    repeat (40) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [11:0] b, b2;
    logic [9:0]  exp_fr;
    logic [7:0]  v;
    int          bad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 txd", int'(txd), 1);
    chk("R1 irq", int'(irq), 0);
    chk("R1 dtr/rts", int'({dtr_o, rts_o}), 0);
    rdchk(6'h00, 8'h06, "R1 lsr");
    rdchk(6'h18, 8'h00, "R1 ctl");
    rdchk(6'h10, 8'h00, "R1 divh");
    rdchk(6'h20, 8'h00, "R1 tcmd");

    // R9 modem outputs
    wr(6'h18, 8'h38);
    chk("R9 dtr/rts set", int'({dtr_o, rts_o}), 3);
    wr(6'h18, 8'h18);
    chk("R9 dtr clear", int'({dtr_o, rts_o}), 1);
    wr(6'h18, 8'h08);

    // R2 divisor bytes
    wr(6'h10, 8'h12); wr(6'h14, 8'h34);
    rdchk(6'h10, 8'h12, "R2 divh");
    rdchk(6'h14, 8'h34, "R2 divl");
    wr(6'h10, 8'h00); wr(6'h14, 8'h00);

    // R3 8N1 frame compared against a clock-by-clock line model
    wr(6'h20, 8'h80);
    exp_fr = {1'b1, 8'hA5, 1'b0};
    wr(6'h24, 8'hA5);
    bad = 0;
    for (int i = 0; i < 170; i++) begin
      @(negedge clk);
      if (txd !== ((i < 160) ? exp_fr[i / 16] : 1'b1)) bad++;
    end
    chk("R3 line model mismatches", bad, 0);
    rdchk(6'h00, 8'h06, "R3 lsr after frame");

    // R14 data write lands on the load cycle
    fork
      begin
        @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 6'h24; bus_wdata = 8'h3C;
        @(negedge clk); bus_wdata = 8'hC3;
        @(negedge clk); bus_sel = 1'b0; bus_wr = 1'b0;
        rdchk(6'h00, 8'h00, "R14 holding empty clear");
      end
      begin
        mon(10, 16, b);
        mon(10, 16, b2);
      end
    join
    chk("R14 first byte", int'(b[8:1]), 'h3C);
    chk("R14 second byte", int'(b2[8:1]), 'hC3);
    repeat (40) @(negedge clk);

    // R3 + R2: 7 data bits, even parity, two stops, divisor 2
    wr(6'h14, 8'h02);
    wr(6'h18, 8'h05);
    fork
      wr(6'h24, 8'h2B);
      mon(11, 48, b);
    join
    chk("R3 7-bit data", int'(b[7:1]), 'h2B);
    chk("R3 even parity bit", int'(b[8]), 0);
    chk("R3 two stop bits", int'(b[10:9]), 3);
    repeat (100) @(negedge clk);
    wr(6'h14, 8'h00);
    wr(6'h18, 8'h08);

    // R12 pause holds back the frame
    wr(6'h20, 8'h84);
    wr(6'h24, 8'h99);
    repeat (50) @(negedge clk);
    rdchk(6'h00, 8'h02, "R12 paused, byte held");
    chk("R12 paused line idle", int'(txd), 1);
    fork
      wr(6'h20, 8'h80);
      mon(10, 16, b);
    join
    chk("R12 released byte", int'(b[8:1]), 'h99);
    repeat (40) @(negedge clk);

    // R12 forced break
    wr(6'h20, 8'h82);
    bad = 0;
    for (int i = 0; i < 5; i++) begin @(negedge clk); if (txd !== 1'b0) bad++; end
    chk("R12 break holds line low", bad, 0);
    wr(6'h20, 8'h80);
    chk("R12 break released", int'(txd), 1);

    // R4 receive
    wr(6'h1C, 8'h80);
    send(10, {2'b11, 1'b1, 8'h3C, 1'b0});
    rdchk(6'h00, 8'h86, "R4 data ready");
    rdchk(6'h24, 8'h3C, "R4 byte");
    rdchk(6'h00, 8'h06, "R4 ready cleared by read");

    // R5 overrun
    send(10, {2'b11, 1'b1, 8'h11, 1'b0});
    send(10, {2'b11, 1'b1, 8'h22, 1'b0});
    rdchk(6'h00, 8'hA6, "R5 overrun flag");
    rdchk(6'h24, 8'h22, "R5 newer byte kept");
    wr(6'h00, 8'h20);
    rdchk(6'h00, 8'h06, "R7 clear overrun");

    // R6 framing error
    send(10, {2'b11, 1'b0, 8'h55, 1'b0});
    rdchk(6'h00, 8'hC6, "R6 framing error");
    rdchk(6'h24, 8'h55, "R6 framing byte");
    wr(6'h00, 8'hF8);
    rdchk(6'h00, 8'h06, "R7 clear errors");

    // R6 break received
    send(10, 12'h000);
    rdchk(6'h00, 8'hCE, "R6 break received");
    rdchk(6'h24, 8'h00, "R6 break data");
    wr(6'h00, 8'h78);

    // R6 parity, 8 bits odd
    wr(6'h18, 8'h0E);
    send(11, {1'b1, 1'b1, 1'b1, 8'h01, 1'b0});
    rdchk(6'h00, 8'h96, "R6 parity error");
    rdchk(6'h24, 8'h01, "R6 parity byte");
    wr(6'h00, 8'hF8);
    send(11, {1'b1, 1'b1, 1'b1, 8'h03, 1'b0});
    rdchk(6'h00, 8'h86, "R6 good parity");
    rdchk(6'h24, 8'h03, "R6 good parity byte");
    wr(6'h18, 8'h08);

    // R7 set address
    wr(6'h04, 8'h80);
    rdchk(6'h00, 8'h86, "R7 set data ready");

    // R13 interrupt sources
    chk("R13 no irq in mode 00", int'(irq), 0);
    wr(6'h1C, 8'hA0);
    chk("R13 rx ready irq", int'(irq), 1);
    wr(6'h00, 8'h80);
    chk("R13 rx irq cleared", int'(irq), 0);
    wr(6'h20, 8'hB0);
    chk("R13 tx empty irq", int'(irq), 1);
    wr(6'h20, 8'h80);
    wr(6'h1C, 8'h90);
    wr(6'h04, 8'h08);
    chk("R13 error irq", int'(irq), 1);
    wr(6'h00, 8'h08);
    chk("R13 error irq cleared", int'(irq), 0);

    // R8 handshake status
    dsr_i = 1'b1;
    rdchk(6'h08, 8'h80, "R8 dsr seen");
    dsr_i = 1'b0;
    rdchk(6'h08, 8'h80, "R8 dsr sticky");
    wr(6'h08, 8'h80);
    rdchk(6'h08, 8'h00, "R8 cleared");
    wr(6'h0C, 8'h40);
    rdchk(6'h08, 8'h40, "R8 set cts bit");

    // R10 loopback
    wr(6'h1C, 8'h80);
    wr(6'h18, 8'h48);
    wr(6'h24, 8'h5A);
    bad = 0;
    for (int i = 0; i < 200; i++) begin @(negedge clk); if (txd !== 1'b1) bad++; end
    chk("R10 txd quiet", bad, 0);
    rdchk(6'h00, 8'h86, "R10 looped ready");
    rdchk(6'h24, 8'h5A, "R10 looped byte");

    // R11 auto-echo
    wr(6'h1C, 8'h00);
    wr(6'h18, 8'h88);
    wr(6'h24, 8'h77);
    repeat (40) @(negedge clk);
    rdchk(6'h00, 8'h02, "R11 cpu byte blocked");
    rxd = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 echo low", int'(txd), 0);
    rxd = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 echo high", int'(txd), 1);
    fork
      wr(6'h18, 8'h08);
      mon(10, 16, b);
    join
    chk("R11 held byte after echo", int'(b[8:1]), 'h77);
    repeat (20) @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule